// File: doc/BRIEF.md
# Preset Down-Counter with Gate

This block is one preset scaler channel. It counts on a qualified count clock, delivered as a single-cycle `tick` enable in the system clock domain. The tick can come from an internal frequency divider or from a synchronized external clock; neither source is part of this block.

The channel has two modes:

- **One-shot mode.** A start loads the preset value and raises `gate_out`. The counter then steps down once per tick. When the countdown ends, the channel drops the gate and emits a stop pulse that lasts one count-clock period.
- **Divider mode.** The channel reloads itself on every wrap. It produces a stop pulse every preset+1 ticks and keeps `gate_out` low.

Starts come from one of two sources. The first is a software strobe. The second, when external start is selected, is the rising edge of the asynchronous `start_in` level after a synchronizer. When external start is selected, a low `start_in` halts the divider.

A capture strobe from a companion scaler copies the live count into an intermediate register. The host can read that register at any time. The block has no streaming data path, so every pin is plain control or status.

Top module: `preset_gate_counter`

## Requirements
- R1: After reset, `gate_out`, `stop_out`, `count_out` and `icount_out` are all zero.
- R2: In one-shot mode (`mode_gen`=0), an accepted start makes `count_out` equal to `preset` and `gate_out` high at the next clock edge. After that, the count drops by exactly one on each cycle with `tick`=1 and holds on cycles without a tick.
- R3: In one-shot mode, `gate_out` stays high for exactly max(preset,1) ticks. The tick that ends the countdown leaves `count_out`=0 and `gate_out`=0.
- R4: `stop_out` rises at the edge that ends a countdown or wraps the divider. It stays high through non-tick cycles and falls at the next tick, so the pulse is one count-clock period wide.
- R5: A start is ignored while the channel is disabled and while a countdown in either mode is running; the count is unchanged.
- R6: In divider mode (`mode_gen`=1), the count steps down on each tick. A tick that finds zero reloads `preset` and raises `stop_out`, so stop pulses begin every preset+1 ticks. `gate_out` stays low throughout.
- R7: With `enable`=0, `gate_out` and `stop_out` are low after the next edge and further ticks leave `count_out` unchanged.
- R8: With `ext_sel`=1, `sw_trig` is ignored. A rising edge on `start_in` starts the channel at the third clock edge after the change (two synchronizer stages plus one edge detect).
- R9: With `ext_sel`=1 in divider mode, a low synchronized `start_in` halts counting at the third edge after the change. From then on, ticks leave the count unchanged.
- R10: When `cap_evt`=1 at an edge, `icount_out` takes the value `count_out` had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel enable; low stops all activity |
| sw_trig | input | 1 | Software start strobe |
| ext_sel | input | 1 | 1 selects `start_in` as the start source |
| start_in | input | 1 | Asynchronous external start level |
| mode_gen | input | 1 | 0 = one-shot, 1 = divider; sampled at start |
| preset | input | W | Preset value |
| tick | input | 1 | Single-cycle count-clock enable |
| cap_evt | input | 1 | Capture strobe from the companion scaler |
| gate_out | output | 1 | High during a one-shot countdown |
| stop_out | output | 1 | One count-period stop pulse |
| count_out | output | W | Live count |
| icount_out | output | W | Captured intermediate count |

## Verification
A wrong count register, or a stale run flag, shows at the ports within one tick. It appears as a `count_out` value that is off by one, or as a gate that lasts one tick too long or too short. A wrong mode flag or a misplaced wrap shows as a stop pulse in the wrong cycle. The scoreboard catches that at the first expected rise of `stop_out`. A synchronizer with the wrong depth moves the external start or halt by a whole cycle, and the bench samples the count exactly at the edge where the start or halt should take effect.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic {
    PGC_ONESHOT = 1'b0,
    PGC_DIVIDE  = 1'b1
  } pgc_mode_e;
endpackage

// File: rtl/pgc_start_sync.sv
module pgc_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[LAST];
  end

  assign level_o = chain_q[LAST];
  assign rise_o  = chain_q[LAST] & ~prev_q;

  // Edge indication lasts a single cycle
  assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pgc_core.sv
module pgc_core
  import pgc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start_req,
  input  logic         halt_lvl,
  input  pgc_mode_e    mode,
  input  logic [W-1:0] preset,
  input  logic         tick,
  output logic         gate,
  output logic         stop,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         run_q, gen_q, gate_q, stop_q;
  logic [W-1:0] count_q;
  logic         start_ok, fin_one, wrap, halt_gen;

  assign start_ok = en && start_req && !run_q;
  assign fin_one  = run_q && !gen_q && tick && (count_q <= ONE);
  assign wrap     = run_q && gen_q && tick && (count_q == '0);
  assign halt_gen = run_q && gen_q && halt_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      gen_q   <= 1'b0;
      gate_q  <= 1'b0;
      count_q <= '0;
    end else if (!en) begin
      run_q  <= 1'b0;
      gate_q <= 1'b0;
    end else if (start_ok) begin
      run_q   <= 1'b1;
      gen_q   <= (mode == PGC_DIVIDE);
      gate_q  <= (mode == PGC_ONESHOT);
      count_q <= preset;
    end else if (halt_gen) begin
      run_q <= 1'b0;
    end else if (run_q && tick) begin
      if (gen_q) begin
        count_q <= (count_q == '0) ? preset : count_q - ONE;
      end else if (count_q <= ONE) begin
        count_q <= '0;
        run_q   <= 1'b0;
        gate_q  <= 1'b0;
      end else begin
        count_q <= count_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               stop_q <= 1'b0;
    else if (!en || halt_gen) stop_q <= 1'b0;
    else if (fin_one || wrap) stop_q <= 1'b1;
    else if (tick)            stop_q <= 1'b0;
  end

  assign gate  = gate_q;
  assign stop  = stop_q;
  assign count = count_q;

  assert_gate_not_divider_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && gen_q) |-> !gate_q);
  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run_q && !gen_q && tick && count_q > ONE && !start_ok) |=> count_q == $past(count_q) - ONE);
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick && !start_ok) |=> $stable(count_q));
  assert_stop_one_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && tick && !run_q) |=> !stop_q);
  assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gate_q && !stop_q));
endmodule

// File: rtl/pgc_capture.sv
module pgc_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] live,
  output logic [W-1:0] held
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   held_q <= '0;
    else if (cap) held_q <= live;
  end

  assign held = held_q;

  assert_capture_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> held_q == $past(live));
endmodule

// File: rtl/preset_gate_counter.sv
module preset_gate_counter
  import pgc_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         sw_trig,
  input  logic         ext_sel,
  input  logic         start_in,
  input  logic         mode_gen,
  input  logic [W-1:0] preset,
  input  logic         tick,
  input  logic         cap_evt,
  output logic         gate_out,
  output logic         stop_out,
  output logic [W-1:0] count_out,
  output logic [W-1:0] icount_out
);
  logic      ext_lvl, ext_rise, start_req, halt_lvl;
  pgc_mode_e mode;

  pgc_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(start_in),
    .level_o(ext_lvl), .rise_o(ext_rise)
  );

  assign start_req = ext_sel ? ext_rise : sw_trig;
  assign halt_lvl  = ext_sel && !ext_lvl;
  assign mode      = mode_gen ? PGC_DIVIDE : PGC_ONESHOT;

  pgc_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(enable), .start_req(start_req),
    .halt_lvl(halt_lvl), .mode(mode), .preset(preset), .tick(tick),
    .gate(gate_out), .stop(stop_out), .count(count_out)
  );

  pgc_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap(cap_evt), .live(count_out), .held(icount_out)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!gate_out && !stop_out && count_out == '0));
endmodule

// File: tb/preset_gate_counter_bench.sv
module preset_gate_counter_bench;
  localparam int  W     = 32;
  localparam time CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic enable = 0, sw_trig = 0, ext_sel = 0, start_in = 0, mode_gen = 0;
  logic tick = 0, cap_evt = 0;
  logic [W-1:0] preset = '0;
  logic gate_out, stop_out;
  logic [W-1:0] count_out, icount_out;

  int checks = 0, fails = 0;
  int edges = 0;
  int exp_q[$];
  logic stop_prev = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  preset_gate_counter #(.W(W)) u_preset_gate_counter (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sw_trig(sw_trig),
    .ext_sel(ext_sel), .start_in(start_in), .mode_gen(mode_gen),
    .preset(preset), .tick(tick), .cap_evt(cap_evt),
    .gate_out(gate_out), .stop_out(stop_out),
    .count_out(count_out), .icount_out(icount_out)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit tk);
    tick = tk;
    @(posedge clk); #1;
    tick = 0; sw_trig = 0; cap_evt = 0;
  endtask

  task automatic push_stop();
    exp_q.push_back(edges + 1);
  endtask

  // Monitor: every rising stop pulse is compared with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && stop_out && !stop_prev) begin
      if (exp_q.size() == 0) chk("R4/R6 unexpected stop rise at edge", edges, -1);
      else chk("R4/R6 stop rise edge", edges, exp_q.pop_front());
    end
    stop_prev = stop_out;
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 gate", gate_out, 0);
    chk("R1 stop", stop_out, 0);
    chk("R1 count", count_out, 0);
    chk("R1 icount", icount_out, 0);
    rst_n = 1;

    // R5: start while disabled
    preset = 7; sw_trig = 1; step(0);
    chk("R5 disabled start gate", gate_out, 0);
    chk("R5 disabled start count", count_out, 0);

    // R2/R3/R4 one-shot, preset 3
    enable = 1; preset = 3; sw_trig = 1; step(0);
    chk("R2 gate after start", gate_out, 1);
    chk("R2 count loaded", count_out, 3);
    step(0); chk("R2 hold without tick", count_out, 3);
    step(1); chk("R2 count after tick1", count_out, 2);
    step(1); chk("R3 gate still high", gate_out, 1);
    push_stop(); step(1);
    chk("R3 gate low at end", gate_out, 0);
    chk("R3 count zero", count_out, 0);
    chk("R4 stop high", stop_out, 1);
    step(0); chk("R4 stop held between ticks", stop_out, 1);
    step(1); chk("R4 stop falls at next tick", stop_out, 0);

    // R5 restart ignored, R10 capture, R7 disable
    preset = 5; sw_trig = 1; step(0);
    step(1); step(1);
    preset = 9; sw_trig = 1; step(0);
    chk("R5 start while running ignored", count_out, 3);
    cap_evt = 1; step(1);
    chk("R10 icount captured pre-edge", icount_out, 3);
    chk("R10 count moved on", count_out, 2);
    enable = 0; step(1);
    chk("R7 gate low on disable", gate_out, 0);
    chk("R7 count frozen", count_out, 2);
    step(1); chk("R7 stop stays low", stop_out, 0);
    enable = 1;

    // R3 preset zero: one tick of gate
    preset = 0; sw_trig = 1; step(0);
    chk("R3 preset0 gate", gate_out, 1);
    push_stop(); step(1);
    chk("R3 preset0 gate drop", gate_out, 0);
    step(1);

    // R6 divider preset 2
    mode_gen = 1; preset = 2; sw_trig = 1; step(0);
    chk("R6 divider load", count_out, 2);
    for (int p = 0; p < 2; p++) begin
      step(1); step(1);
      push_stop(); step(1);
      chk("R6 reload", count_out, 2);
      chk("R6 gate low", gate_out, 0);
    end
    step(1);
    chk("R6 count after wrap", count_out, 1);
    chk("R6 stop one period", stop_out, 0);
    enable = 0; step(0); enable = 1;
    step(1); chk("R7 divider stopped", count_out, 1);

    // R8/R9 external start in divider mode
    ext_sel = 1; preset = 4; sw_trig = 1; step(0);
    step(1); chk("R8 sw trigger ignored", count_out, 1);
    start_in = 1; step(0); step(0);
    chk("R8 no start before third edge", count_out, 1);
    step(0); chk("R8 started at third edge", count_out, 4);
    step(1); chk("R8 counting", count_out, 3);
    start_in = 0; step(1); step(1);
    chk("R9 still counting two edges", count_out, 1);
    step(1); chk("R9 halted at third edge", count_out, 1);
    step(1); chk("R9 halted stays", count_out, 1);

    step(0); step(0);
    chk("R4/R6 scoreboard drained", exp_q.size(), 0);
    done = 1;
    report();
  end
endmodule